// File: doc/BRIEF.md
# Command-Driven Sample Buffer Controller

This block carries samples between one attached peripheral and a local 1K-word I/O RAM. Incoming samples land in a circular input region. Outgoing samples are fetched from a circular output region. Each region is defined by a base address and a limit address. When a pointer steps past its limit, it returns to its base.

Software steers the block with 16-bit command words. A command word holds a 4-bit opcode in bits 15:12 and a 12-bit argument in bits 11:0. Software can also read and overwrite the two 10-bit RAM pointers directly. A signed counter tracks input samples and raises a flag once it drops below zero. An unsigned counter meters how many output samples may still be fetched.

The input side is a valid/ready sink whose ready is held high. The peripheral may therefore hand over one sample every cycle, and each sample is written to RAM in the same cycle. The output side is a valid/ready source backed by a one-word holding register. Once out_valid rises, out_valid and out_data stay unchanged until out_ready is seen high at a clock edge. A new word is fetched only after the held word has been taken. The output stream therefore delivers at most one sample every three cycles.

Top module: `bufc_top`

## Requirements
- R1: A command word executes at the clock edge where cmd_we is high. Opcodes 0x0, 0x1, 0x3 and 0x4 load the input base, input limit, output base and output limit, each from argument bits 9:0.
- R2: iwp_rdata and orp_rdata present the 10-bit input write and output read pointers with bits 15:10 at zero. A software write (iwp_we / orp_we) takes bits 9:0 of its data.
- R3: in_ready is high outside reset. Each cycle with in_valid high writes one RAM word at the current input pointer (ram_we high, ram_waddr equal to the pointer), and the pointer then advances by one.
- R4: A pointer that advances while equal to its limit takes its base value on that same edge. This holds for both the input and the output pointer.
- R5: Opcode 0x2 loads the signed 12-bit input counter from the argument. Each accepted input sample decrements it. in_len_neg shows its sign bit, so 0x800 reads as negative at once.
- R6: Opcode 0x5 loads the 11-bit output counter from argument bits 10:0. Each RAM fetch for the output stream decrements it. No fetch is issued while it is zero.
- R7: Once out_valid is high, out_valid and out_data hold steady until out_ready is sampled high. Words are delivered in pointer order, and the output pointer advances when a word is fetched.
- R8: With mode_8b high, an input sample is stored as {8'h00, in_data[7:0]}, and an output word is delivered as {8'h00, word[7:0]}. With mode_8b low, full 16-bit words pass unchanged.
- R9: Opcode 0x6 and every opcode from 0x7 to 0xF clear both pointers and both counters and discard any held or pending output word. The argument is ignored, and base and limit values are kept.
- R10: When actions coincide in one cycle, a clear command wins over a software pointer write, which wins over a pointer advance. An input sample taken in that cycle is still written at the pointer value from before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Command word strobe |
| cmd_word | input | 16 | Opcode (15:12) and argument (11:0) |
| iwp_we | input | 1 | Software write of the input pointer |
| iwp_wdata | input | 16 | Input pointer write data |
| orp_we | input | 1 | Software write of the output pointer |
| orp_wdata | input | 16 | Output pointer write data |
| iwp_rdata | output | 16 | Input write pointer readback |
| orp_rdata | output | 16 | Output read pointer readback |
| mode_8b | input | 1 | Byte-wide sample mode |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample ready |
| in_data | input | 16 | Input sample |
| in_len_neg | output | 1 | Input counter is negative |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Output sample accepted |
| out_data | output | 16 | Output sample |
| ram_we | output | 1 | RAM write strobe |
| ram_waddr | output | 10 | RAM write address |
| ram_wdata | output | 16 | RAM write data |
| ram_re | output | 1 | RAM read strobe |
| ram_raddr | output | 10 | RAM read address |
| ram_rdata | input | 16 | RAM read data, one cycle after ram_re |

## Verification
A peripheral sample can arrive in the same cycle as software overwriting the input pointer. It can also arrive in the same cycle as a clear command. The bench raises in_valid together with iwp_we in one cycle, and together with a reset command in another cycle. It then judges the outcome from the RAM word at the old pointer address and from the pointer value read back on the next cycle. Wrap-around on both pointers is also checked, as is the output counter stopping the fetches.

// File: rtl/bufc_pkg.sv
package bufc_pkg;

  localparam int CMD_W = 16;
  localparam int OP_W  = 4;
  localparam int ARG_W = 12;

  typedef enum logic [OP_W-1:0] {
    OP_IBASE = 4'h0,
    OP_ILIM  = 4'h1,
    OP_ILEN  = 4'h2,
    OP_OBASE = 4'h3,
    OP_OLIM  = 4'h4,
    OP_OLEN  = 4'h5,
    OP_RESET = 4'h6
  } op_e;

  // decoded action of one command word, valid in the cycle of the strobe
  typedef struct packed {
    logic             clr;
    logic             ilen_ld;
    logic             olen_ld;
    logic [ARG_W-1:0] arg;
  } ctl_t;

  // right-justify a 16-bit sample when the byte mode is selected
  function automatic logic [15:0] justify(input logic [15:0] w, input logic narrow);
    return narrow ? {8'h00, w[7:0]} : w;
  endfunction

endpackage

// File: rtl/bufc_cmd_dec.sv
module bufc_cmd_dec
  import bufc_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_we,
  input  logic [CMD_W-1:0]     cmd_word,
  output logic [AW-1:0]        ibase,
  output logic [AW-1:0]        ilim,
  output logic [AW-1:0]        obase,
  output logic [AW-1:0]        olim,
  output ctl_t                 ctl
);

  localparam int NCFG = 4;

  logic [OP_W-1:0]  op;
  logic [ARG_W-1:0] arg;
  logic [AW-1:0]    cfg_q [NCFG];

  assign op  = cmd_word[CMD_W-1 -: OP_W];
  assign arg = cmd_word[ARG_W-1:0];

  // slot g is loaded by opcode g for the inputs, g+1 for the outputs
  function automatic logic [OP_W-1:0] slot_op(input int g);
    return (g < 2) ? OP_W'(g) : OP_W'(g + 1);
  endfunction

  // reset value of each slot: bases at zero, limits at the top address
  function automatic logic [AW-1:0] slot_init(input int g);
    return (g % 2 == 1) ? {AW{1'b1}} : {AW{1'b0}};
  endfunction

  for (genvar g = 0; g < NCFG; g++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cfg_q[g] <= slot_init(g);
      else if (cmd_we && op == slot_op(g))
        cfg_q[g] <= arg[AW-1:0];
    end
  end

  assign ibase = cfg_q[0];
  assign ilim  = cfg_q[1];
  assign obase = cfg_q[2];
  assign olim  = cfg_q[3];

  always_comb begin
    ctl.arg     = arg;
    ctl.ilen_ld = cmd_we && (op == OP_ILEN);
    ctl.olen_ld = cmd_we && (op == OP_OLEN);
    ctl.clr     = cmd_we && (op >= OP_RESET);
  end

  p_base_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && op == OP_IBASE) |=> ibase == $past(cmd_word[AW-1:0]));

  p_cfg_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && op >= OP_RESET) |=> ($stable(ibase) && $stable(ilim) && $stable(obase) && $stable(olim)));

endmodule

// File: rtl/bufc_in_path.sv
module bufc_in_path
  import bufc_pkg::*;
#(
  parameter int AW  = 10,
  parameter int ILW = 12,
  parameter int DW  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctl_t          ctl,
  input  logic [AW-1:0] ibase,
  input  logic [AW-1:0] ilim,
  input  logic          sw_we,
  input  logic [AW-1:0] sw_ptr,
  input  logic          mode_8b,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          ram_we,
  output logic [AW-1:0] ram_waddr,
  output logic [DW-1:0] ram_wdata,
  output logic [AW-1:0] iwp,
  output logic          len_neg
);

  logic [AW-1:0]  iwp_q, iwp_nx;
  logic [ILW-1:0] ilen_q;
  logic           take;

  assign take   = in_valid;
  assign iwp_nx = (iwp_q == ilim) ? ibase : iwp_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          iwp_q <= '0;
    else if (ctl.clr)    iwp_q <= '0;
    else if (sw_we)      iwp_q <= sw_ptr;
    else if (take)       iwp_q <= iwp_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ilen_q <= '0;
    else if (ctl.clr)    ilen_q <= '0;
    else if (ctl.ilen_ld) ilen_q <= ctl.arg[ILW-1:0];
    else if (take)       ilen_q <= ilen_q - 1'b1;
  end

  assign ram_we    = take;
  assign ram_waddr = iwp_q;
  assign ram_wdata = justify(in_data, mode_8b);
  assign iwp       = iwp_q;
  assign len_neg   = ilen_q[ILW-1];

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !ctl.clr && !sw_we && iwp_q != ilim) |=> iwp_q == $past(iwp_q) + 1'b1);

  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !ctl.clr && !sw_we && iwp_q == ilim) |=> iwp_q == $past(ibase));

  p_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !ctl.clr && !ctl.ilen_ld) |=> ilen_q == $past(ilen_q) - 1'b1);

  p_sw_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_we && !ctl.clr) |=> iwp_q == $past(sw_ptr));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.clr |=> (iwp_q == '0 && !len_neg));

endmodule

// File: rtl/bufc_out_path.sv
module bufc_out_path
  import bufc_pkg::*;
#(
  parameter int AW  = 10,
  parameter int OLW = 11,
  parameter int DW  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctl_t          ctl,
  input  logic [AW-1:0] obase,
  input  logic [AW-1:0] olim,
  input  logic          sw_we,
  input  logic [AW-1:0] sw_ptr,
  input  logic          mode_8b,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          ram_re,
  output logic [AW-1:0] ram_raddr,
  input  logic [DW-1:0] ram_rdata,
  output logic [AW-1:0] orp
);

  logic [AW-1:0]  orp_q, orp_nx;
  logic [OLW-1:0] olen_q;
  logic           pend_q, hold_q;
  logic [DW-1:0]  data_q;
  logic           fetch;

  assign fetch  = !pend_q && !hold_q && (olen_q != '0) && !ctl.clr;
  assign orp_nx = (orp_q == olim) ? obase : orp_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          orp_q <= '0;
    else if (ctl.clr)    orp_q <= '0;
    else if (sw_we)      orp_q <= sw_ptr;
    else if (fetch)      orp_q <= orp_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           olen_q <= '0;
    else if (ctl.clr)     olen_q <= '0;
    else if (ctl.olen_ld) olen_q <= ctl.arg[OLW-1:0];
    else if (fetch)       olen_q <= olen_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      hold_q <= 1'b0;
    end else if (ctl.clr) begin
      pend_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      pend_q <= fetch;
      if (pend_q)                 hold_q <= 1'b1;
      else if (hold_q && out_ready) hold_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (pend_q) data_q <= justify(ram_rdata, mode_8b);
  end

  assign ram_re    = fetch;
  assign ram_raddr = orp_q;
  assign out_valid = hold_q;
  assign out_data  = data_q;
  assign orp       = orp_q;

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !out_ready && !ctl.clr) |=> (hold_q && $stable(data_q)));

  p_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !ctl.clr) |=> hold_q);

  p_meter_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_re && !ctl.olen_ld) |=> olen_q == $past(olen_q) - 1'b1);

  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_re && !sw_we && orp_q == olim) |=> orp_q == $past(obase));

  p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.clr |=> (!hold_q && !pend_q && orp_q == '0));

endmodule

// File: rtl/bufc_top.sv
module bufc_top
  import bufc_pkg::*;
#(
  parameter int AW  = 10,
  parameter int ILW = 12,
  parameter int OLW = 11,
  parameter int DW  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_we,
  input  logic [15:0]   cmd_word,
  input  logic          iwp_we,
  input  logic [15:0]   iwp_wdata,
  input  logic          orp_we,
  input  logic [15:0]   orp_wdata,
  output logic [15:0]   iwp_rdata,
  output logic [15:0]   orp_rdata,
  input  logic          mode_8b,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          in_len_neg,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          ram_we,
  output logic [AW-1:0] ram_waddr,
  output logic [DW-1:0] ram_wdata,
  output logic          ram_re,
  output logic [AW-1:0] ram_raddr,
  input  logic [DW-1:0] ram_rdata
);

  localparam int PAD = 16 - AW;

  logic [AW-1:0] ibase, ilim, obase, olim;
  logic [AW-1:0] iwp, orp;
  ctl_t          ctl;

  bufc_cmd_dec #(.AW(AW)) u_dec (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_word(cmd_word),
    .ibase(ibase), .ilim(ilim), .obase(obase), .olim(olim), .ctl(ctl)
  );

  bufc_in_path #(.AW(AW), .ILW(ILW), .DW(DW)) u_in (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .ibase(ibase), .ilim(ilim),
    .sw_we(iwp_we), .sw_ptr(iwp_wdata[AW-1:0]), .mode_8b(mode_8b),
    .in_valid(in_valid), .in_data(in_data),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .iwp(iwp), .len_neg(in_len_neg)
  );

  bufc_out_path #(.AW(AW), .OLW(OLW), .DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .obase(obase), .olim(olim),
    .sw_we(orp_we), .sw_ptr(orp_wdata[AW-1:0]), .mode_8b(mode_8b),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .ram_re(ram_re), .ram_raddr(ram_raddr), .ram_rdata(ram_rdata),
    .orp(orp)
  );

  assign in_ready  = rst_n;
  assign iwp_rdata = {{PAD{1'b0}}, iwp};
  assign orp_rdata = {{PAD{1'b0}}, orp};

  p_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (ram_we && ram_waddr == iwp_rdata[AW-1:0]));

endmodule

// File: tb/sim_bufc_top.sv
module sim_bufc_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0;
  logic [15:0] cmd_word = '0;
  logic        iwp_we = 1'b0;
  logic [15:0] iwp_wdata = '0;
  logic        orp_we = 1'b0;
  logic [15:0] orp_wdata = '0;
  logic [15:0] iwp_rdata, orp_rdata;
  logic        mode_8b = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        in_len_neg;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_data;
  logic        ram_we, ram_re;
  logic [9:0]  ram_waddr, ram_raddr;
  logic [15:0] ram_wdata;
  logic [15:0] ram_rdata = '0;
  logic [15:0] mem [0:1023];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bufc_top u0 (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_word(cmd_word),
    .iwp_we(iwp_we), .iwp_wdata(iwp_wdata), .orp_we(orp_we), .orp_wdata(orp_wdata),
    .iwp_rdata(iwp_rdata), .orp_rdata(orp_rdata), .mode_8b(mode_8b),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_len_neg(in_len_neg), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .ram_we(ram_we), .ram_waddr(ram_waddr),
    .ram_wdata(ram_wdata), .ram_re(ram_re), .ram_raddr(ram_raddr),
    .ram_rdata(ram_rdata)
  );

  always @(posedge clk) begin
    if (ram_we) mem[ram_waddr] <= ram_wdata;
    if (ram_re) ram_rdata <= mem[ram_raddr];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [3:0] op, input logic [11:0] arg);
    @(negedge clk);
    cmd_we = 1'b1; cmd_word = {op, arg};
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic set_iwp(input logic [15:0] v);
    @(negedge clk);
    iwp_we = 1'b1; iwp_wdata = v;
    @(negedge clk);
    iwp_we = 1'b0;
  endtask

  task automatic set_orp(input logic [15:0] v);
    @(negedge clk);
    orp_we = 1'b1; orp_wdata = v;
    @(negedge clk);
    orp_we = 1'b0;
  endtask

  task automatic push(input logic [15:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_valid();
    for (int n = 0; n < 40 && !out_valid; n++) @(negedge clk);
  endtask

  task automatic pop(output logic [15:0] d);
    wait_valid();
    d = out_data;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk("R2 reset iwp", iwp_rdata, 16'h0000);
    chk("R2 reset orp", orp_rdata, 16'h0000);
    chk("R3 in_ready", in_ready, 1'b1);
    chk("R7 reset out_valid", out_valid, 1'b0);
    chk("R5 reset flag", in_len_neg, 1'b0);
  endtask

  task automatic t_ptr_rw();
    set_iwp(16'hFFFF);
    chk("R2 iwp upper bits", iwp_rdata, 16'h03FF);
    set_orp(16'hFC21);
    chk("R2 orp upper bits", orp_rdata, 16'h0021);
  endtask

  task automatic t_input_wrap();
    cmd(4'h0, 12'h100);
    cmd(4'h1, 12'h102);
    set_iwp(16'h0100);
    push(16'hA001);
    chk("R3 ptr step", iwp_rdata, 16'h0101);
    push(16'hA002);
    push(16'hA003);
    chk("R4 input wrap to base", iwp_rdata, 16'h0100);
    push(16'hA004);
    chk("R3 word at base", mem[10'h100], 16'hA004);
    chk("R3 word next", mem[10'h101], 16'hA002);
    chk("R4 word at limit", mem[10'h102], 16'hA003);
    chk("R1 base via wrap", iwp_rdata, 16'h0101);
  endtask

  task automatic t_len();
    cmd(4'h2, 12'h002);
    chk("R5 loaded positive", in_len_neg, 1'b0);
    push(16'h0001);
    push(16'h0002);
    chk("R5 zero not negative", in_len_neg, 1'b0);
    push(16'h0003);
    chk("R5 below zero", in_len_neg, 1'b1);
    cmd(4'h2, 12'h800);
    chk("R5 load 0x800 negative", in_len_neg, 1'b1);
  endtask

  task automatic t_just_in();
    set_iwp(16'h0200);
    mode_8b = 1'b1;
    push(16'h1234);
    mode_8b = 1'b0;
    push(16'h5678);
    chk("R8 byte input", mem[10'h200], 16'h0034);
    chk("R8 word input", mem[10'h201], 16'h5678);
  endtask

  task automatic t_output();
    logic [15:0] d;
    mem[10'h040] = 16'h1111;
    mem[10'h041] = 16'h2222;
    mem[10'h042] = 16'h3333;
    cmd(4'h3, 12'h040);
    cmd(4'h4, 12'h042);
    set_orp(16'h0040);
    repeat (4) @(negedge clk);
    chk("R6 no fetch at zero count", out_valid, 1'b0);
    cmd(4'h5, 12'h004);
    wait_valid();
    chk("R7 first word", out_data, 16'h1111);
    chk("R7 ptr after fetch", orp_rdata, 16'h0041);
    repeat (5) @(negedge clk);
    chk("R7 held valid", out_valid, 1'b1);
    chk("R7 held data", out_data, 16'h1111);
    pop(d); chk("R7 pop 1", d, 16'h1111);
    pop(d); chk("R7 pop 2", d, 16'h2222);
    pop(d); chk("R4 pop at limit", d, 16'h3333);
    pop(d); chk("R4 output wrap", d, 16'h1111);
    repeat (10) @(negedge clk);
    chk("R6 count exhausted", out_valid, 1'b0);
    chk("R6 ptr stopped", orp_rdata, 16'h0041);
  endtask

  task automatic t_just_out();
    logic [15:0] d;
    mem[10'h050] = 16'hABCD;
    set_orp(16'h0050);
    mode_8b = 1'b1;
    cmd(4'h5, 12'h001);
    pop(d);
    mode_8b = 1'b0;
    chk("R8 byte output", d, 16'h00CD);
  endtask

  task automatic t_clear();
    set_orp(16'h0040);
    cmd(4'h5, 12'h003);
    cmd(4'h2, 12'h900);
    wait_valid();
    chk("R9 pre-clear valid", out_valid, 1'b1);
    cmd(4'h6, 12'hFFF);
    chk("R9 out dropped", out_valid, 1'b0);
    chk("R9 orp cleared", orp_rdata, 16'h0000);
    chk("R9 iwp cleared", iwp_rdata, 16'h0000);
    chk("R9 counter cleared", in_len_neg, 1'b0);
    repeat (10) @(negedge clk);
    chk("R9 out count cleared", out_valid, 1'b0);
    set_iwp(16'h0123);
    cmd(4'hA, 12'h155);
    chk("R9 unassigned clears", iwp_rdata, 16'h0000);
    set_iwp(16'h0102);
    push(16'h7777);
    chk("R9 base and limit kept", iwp_rdata, 16'h0100);
  endtask

  task automatic t_collide();
    set_iwp(16'h0100);
    @(negedge clk);
    in_valid = 1'b1; in_data = 16'h5A5A;
    iwp_we = 1'b1; iwp_wdata = 16'h01F0;
    @(negedge clk);
    in_valid = 1'b0; iwp_we = 1'b0;
    chk("R10 sw write beats step", iwp_rdata, 16'h01F0);
    chk("R10 sample at old ptr", mem[10'h100], 16'h5A5A);
    @(negedge clk);
    in_valid = 1'b1; in_data = 16'h6B6B;
    cmd_we = 1'b1; cmd_word = 16'h6000;
    iwp_we = 1'b1; iwp_wdata = 16'h0033;
    @(negedge clk);
    in_valid = 1'b0; cmd_we = 1'b0; iwp_we = 1'b0;
    chk("R10 clear beats all", iwp_rdata, 16'h0000);
    chk("R10 sample kept on clear", mem[10'h1F0], 16'h6B6B);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ptr_rw();
    t_input_wrap();
    t_len();
    t_just_in();
    t_output();
    t_just_out();
    t_clear();
    t_collide();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule